// File: doc/BRIEF.md
# Audio DMA Transfer Controller

This block turns the playback commands of a sound device into the settings of a DMA transfer and then tracks the transfer byte by byte. A command byte stream arrives on a simple valid/byte interface: an opcode followed by the argument bytes that the opcode requires. From it the block derives the sample width, signedness and channel count, the FIFO and auto-initialise flags, the DMA channel choice, the transfer buffer size in bytes and the sample rate. The sample rate is either given directly or derived from an 8-bit time constant by a rounded division.

While a transfer runs, the DMA engine pulses a strobe for every byte it moves. The block advances a buffer position that wraps at the DMA channel length and counts down the bytes left in the current block. When the countdown is used up, it emits a one-cycle interrupt-set pulse and reloads the countdown. In single-cycle mode it also drops the DMA request hold, so no further bytes move. Memory access and audio output are left to neighbouring blocks.

The time-constant division runs over several cycles. A busy output covers that time, and a transfer that needs the new rate starts only once the quotient is ready.

Top module: `pcm_xfer_ctrl`

## Requirements
- R1: A start opcode is any value from 0xB0 to 0xCF with bit 3 clear, followed by three argument bytes. In the opcode, bit 1 gives fifoOn and bit 2 gives autoInit. A high nibble of 0xB gives 16-bit samples (sampleWide=1), and 0xC gives 8-bit samples. Opcodes below 0xC0 set highChan.
- R2: In the first argument of a start opcode (the mode byte), bit 4 drives sampleSigned and bit 5 drives sampleStereo.
- R3: The length field of a start opcode is the second argument plus the third argument times 256. The buffer size is (length+1) bytes for 8-bit samples and 2*(length+1) bytes for 16-bit samples. Completing the start clears bufPos, loads the byte countdown with the buffer size, and sets both dreqHold and speakerOn.
- R4: Opcode 0x40 with one argument stores a time constant tc. Every later start then sets freqHz to (1000000 + t/2)/t, where t = 256-tc and the division is an integer division. While this division runs, busy is high, the start has not yet taken effect, and bufPos and dreqHold hold still.
- R5: Opcodes 0x41 and 0x42 take two arguments, high byte first, and load freqHz directly. They also discard any stored time constant, so later starts leave freqHz unchanged and never raise busy.
- R6: Opcode 0x48 takes two arguments, high byte first, and sets the buffer size in bytes directly. A following 0x90 or 0x91 start uses that size.
- R7: Opcode 0x14 takes two arguments, low byte first, and sets an 8-bit, unsigned, mono, single-cycle, low-channel format with a buffer size of (value+1) bytes. It keeps the current bufPos and the current byte countdown, and sets dreqHold and speakerOn.
- R8: Opcode 0x90 starts an 8-bit unsigned mono auto-initialise transfer with no arguments. Opcode 0x91 starts the same transfer in single-cycle mode. Both clear fifoOn and highChan.
- R9: A byte moves on an xferStrobe cycle when speakerOn and dreqHold are set and busy is low. The byte that exhausts the countdown raises irqSet for one cycle, and the countdown then reloads with the buffer size.
- R10: In single-cycle mode, the interrupt that ends a block also clears dreqHold. Strobes after that point leave bufPos unchanged.
- R11: bufPos increments once per moved byte and returns to 0 when the incremented value equals chanLen.
- R12: Opcode 0xD3 clears speakerOn, and strobes are then ignored. Opcode 0xD1 sets speakerOn again.
- R13: Opcodes 0xD4 and 0xD6 set dreqHold. Opcodes 0xD0 and 0xD5 clear it. Opcodes 0xD9 and 0xDA clear both dreqHold and autoInit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte present this cycle |
| cmdByte | input | 8 | Opcode or argument byte |
| xferStrobe | input | 1 | One byte moved by the DMA engine |
| chanLen | input | 16 | DMA channel length used for the position wrap |
| busy | output | 1 | Rate division in progress; command bytes are not accepted |
| sampleWide | output | 1 | 16-bit samples |
| sampleSigned | output | 1 | Signed samples |
| sampleStereo | output | 1 | Two channels |
| fifoOn | output | 1 | FIFO enabled |
| autoInit | output | 1 | Auto-initialise mode |
| highChan | output | 1 | High (16-bit) DMA channel selected |
| freqHz | output | 20 | Sample rate |
| bufPos | output | 16 | Current buffer position |
| dreqHold | output | 1 | DMA request held |
| speakerOn | output | 1 | Output enabled |
| irqSet | output | 1 | One-cycle interrupt-set pulse |

## Verification
Several properties are checked on every cycle:
- an interrupt pulse always follows a moved byte;
- a single-cycle block end always drops the request hold;
- the position never moves while the speaker is off or the division is running;
- the position wraps to zero at the channel length.

The bench scenarios cover what only a command sequence can show:
- the decoded format fields and the rounded time-constant rate;
- the byte count at which each interrupt arrives, including the 0x14 case where the old countdown must survive a size change;
- the selection between a directly loaded rate and a computed one.

// File: rtl/pcm_xfer_pkg.sv
package pcm_xfer_pkg;
  localparam int LEN_W  = 16;
  localparam int SIZE_W = LEN_W + 2;
  localparam int FREQ_W = 20;
  localparam int TC_W   = 8;

  typedef enum logic [1:0] {
    START_FULL,
    START_LEGACY,
    START_RESIZE
  } startKind_e;

  typedef struct packed {
    logic wide;
    logic sgn;
    logic stereo;
    logic fifo;
    logic autoInit;
    logic highChan;
  } fmt_t;

  typedef struct packed {
    startKind_e        kind;
    fmt_t              fmt;
    logic              loadSize;
    logic [SIZE_W-1:0] size;
  } startInfo_t;

  typedef struct packed {
    logic              startReq;
    startInfo_t        info;
    logic              setTc;
    logic [TC_W-1:0]   tcVal;
    logic              setFreq;
    logic [LEN_W-1:0]  freqVal;
    logic              setSize;
    logic              holdOn;
    logic              holdOff;
    logic              spkOn;
    logic              spkOff;
    logic              autoOff;
  } strobe_t;
endpackage

// File: rtl/pcm_tc_divider.sv
module pcm_tc_divider #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remR;
  logic [DEN_W-1:0] denR;
  logic [CNT_W-1:0] stepsLeft;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {remR, quo[NUM_W-1]};
  assign fits  = trial >= {1'b0, denR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      quo       <= '0;
      remR      <= '0;
      denR      <= '0;
      stepsLeft <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        quo       <= num;
        remR      <= '0;
        denR      <= den;
        stepsLeft <= CNT_W'(NUM_W);
      end else if (busy) begin
        remR      <= fits ? DEN_W'(trial - {1'b0, denR}) : trial[DEN_W-1:0];
        quo       <= {quo[NUM_W-2:0], fits};
        stepsLeft <= stepsLeft - 1'b1;
        if (stepsLeft == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_xfer_cmd.sv
module pcm_xfer_cmd
  import pcm_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       busy,
  output strobe_t    strb
);
  logic [1:0] needCnt;
  logic [1:0] idx;
  logic [7:0] opReg;
  logic [7:0] arg0, arg1;
  logic [7:0] a0, a1, a2;
  logic       accept, opPhase, finishing;
  logic [LEN_W-1:0] lenField;

  function automatic logic isStartOp(input logic [7:0] op);
    return (op >= 8'hB0) && (op <= 8'hCF) && !op[3];
  endfunction

  function automatic logic [1:0] needOf(input logic [7:0] op);
    if (isStartOp(op)) return 2'd3;
    case (op)
      8'h40:                      return 2'd1;
      8'h41, 8'h42, 8'h48, 8'h14: return 2'd2;
      default:                    return 2'd0;
    endcase
  endfunction

  assign accept    = cmdValid && !busy;
  assign opPhase   = accept && (needCnt == 2'd0);
  assign finishing = accept && (needCnt != 2'd0) && (idx == needCnt - 2'd1);
  assign a0        = (idx == 2'd0) ? cmdByte : arg0;
  assign a1        = (idx == 2'd1) ? cmdByte : arg1;
  assign a2        = cmdByte;
  assign lenField  = {a2, a1};

  always_comb begin
    strb = '0;
    strb.info.kind = START_FULL;
    if (opPhase) begin
      case (cmdByte)
        8'h90, 8'h91: begin
          strb.startReq           = 1'b1;
          strb.info.kind          = START_LEGACY;
          strb.info.fmt.autoInit  = (cmdByte == 8'h90);
        end
        8'hD0, 8'hD5: strb.holdOff = 1'b1;
        8'hD4, 8'hD6: strb.holdOn  = 1'b1;
        8'hD1:        strb.spkOn   = 1'b1;
        8'hD3:        strb.spkOff  = 1'b1;
        8'hD9, 8'hDA: begin
          strb.holdOff = 1'b1;
          strb.autoOff = 1'b1;
        end
        default: ;
      endcase
    end else if (finishing) begin
      if (isStartOp(opReg)) begin
        strb.startReq          = 1'b1;
        strb.info.kind         = START_FULL;
        strb.info.fmt.wide     = (opReg[7:4] == 4'hB);
        strb.info.fmt.highChan = (opReg < 8'hC0);
        strb.info.fmt.fifo     = opReg[1];
        strb.info.fmt.autoInit = opReg[2];
        strb.info.fmt.sgn      = a0[4];
        strb.info.fmt.stereo   = a0[5];
        strb.info.loadSize     = 1'b1;
        strb.info.size         = ({2'b00, lenField} + SIZE_W'(1)) << (opReg[7:4] == 4'hB);
      end else begin
        case (opReg)
          8'h40: begin
            strb.setTc = 1'b1;
            strb.tcVal = a0;
          end
          8'h41, 8'h42: begin
            strb.setFreq = 1'b1;
            strb.freqVal = {a0, a1};
          end
          8'h48: begin
            strb.setSize   = 1'b1;
            strb.info.size = {2'b00, a0, a1};
          end
          8'h14: begin
            strb.startReq      = 1'b1;
            strb.info.kind     = START_RESIZE;
            strb.info.loadSize = 1'b1;
            strb.info.size     = {2'b00, a1, a0} + SIZE_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      needCnt <= '0;
      idx     <= '0;
      opReg   <= '0;
      arg0    <= '0;
      arg1    <= '0;
    end else if (opPhase) begin
      opReg   <= cmdByte;
      needCnt <= needOf(cmdByte);
      idx     <= '0;
    end else if (finishing) begin
      needCnt <= '0;
      idx     <= '0;
    end else if (accept) begin
      if (idx == 2'd0) arg0 <= cmdByte;
      if (idx == 2'd1) arg1 <= cmdByte;
      idx <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/pcm_xfer_dp.sv
module pcm_xfer_dp
  import pcm_xfer_pkg::*;
#(
  parameter int RATE_NUM = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              xferStrobe,
  input  logic [LEN_W-1:0]  chanLen,
  output fmt_t              fmt,
  output logic [FREQ_W-1:0] freqHz,
  output logic [LEN_W-1:0]  bufPos,
  output logic              dreqHold,
  output logic              speakerOn,
  output logic              irqSet,
  output logic              busy
);
  localparam int DEN_W = TC_W + 1;

  logic [SIZE_W-1:0] bufSize, countLeft;
  logic              tcValid;
  logic [TC_W-1:0]   tcR;
  startInfo_t        pendR, cInfo;
  logic              divBusy, divDone;
  logic [FREQ_W-1:0] divQuo;
  logic [DEN_W-1:0]  tmpDen;
  logic [FREQ_W-1:0] dividend;
  logic              commitNow, commit, moveOk;
  logic [LEN_W-1:0]  posInc;

  assign tmpDen    = DEN_W'(1 << TC_W) - {1'b0, tcR};
  assign dividend  = FREQ_W'(RATE_NUM) + FREQ_W'(tmpDen >> 1);
  assign commitNow = strb.startReq && !tcValid;
  assign commit    = commitNow || divDone;
  assign cInfo     = divDone ? pendR : strb.info;
  assign busy      = divBusy || divDone;
  assign moveOk    = xferStrobe && speakerOn && dreqHold && !busy && !commit;
  assign posInc    = bufPos + 1'b1;

  pcm_tc_divider #(.NUM_W(FREQ_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (strb.startReq && tcValid),
    .num   (dividend),
    .den   (tmpDen),
    .busy  (divBusy),
    .done  (divDone),
    .quo   (divQuo)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmt       <= '0;
      freqHz    <= '0;
      bufPos    <= '0;
      dreqHold  <= 1'b0;
      speakerOn <= 1'b0;
      irqSet    <= 1'b0;
      bufSize   <= '0;
      countLeft <= '0;
      tcValid   <= 1'b0;
      tcR       <= '0;
      pendR     <= '0;
    end else begin
      irqSet <= 1'b0;
      if (strb.startReq) pendR <= strb.info;
      if (strb.setTc) begin
        tcValid <= 1'b1;
        tcR     <= strb.tcVal;
      end
      if (strb.setFreq) begin
        tcValid <= 1'b0;
        freqHz  <= FREQ_W'(strb.freqVal);
      end
      if (strb.setSize) bufSize <= strb.info.size;
      if (strb.holdOn)  dreqHold  <= 1'b1;
      if (strb.holdOff) dreqHold  <= 1'b0;
      if (strb.spkOn)   speakerOn <= 1'b1;
      if (strb.spkOff)  speakerOn <= 1'b0;
      if (strb.autoOff) fmt.autoInit <= 1'b0;

      if (commit) begin
        fmt <= cInfo.fmt;
        if (cInfo.loadSize) bufSize <= cInfo.size;
        if (cInfo.kind != START_RESIZE) begin
          bufPos    <= '0;
          countLeft <= cInfo.loadSize ? cInfo.size : bufSize;
        end
        if (divDone) freqHz <= divQuo;
        dreqHold  <= 1'b1;
        speakerOn <= 1'b1;
      end else if (moveOk) begin
        bufPos <= (posInc == chanLen) ? '0 : posInc;
        if (countLeft <= SIZE_W'(1)) begin
          irqSet    <= 1'b1;
          countLeft <= bufSize;
          if (!fmt.autoInit) dreqHold <= 1'b0;
        end else begin
          countLeft <= countLeft - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_xfer_ctrl.sv
module pcm_xfer_ctrl
  import pcm_xfer_pkg::*;
#(
  parameter int RATE_NUM = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              xferStrobe,
  input  logic [LEN_W-1:0]  chanLen,
  output logic              busy,
  output logic              sampleWide,
  output logic              sampleSigned,
  output logic              sampleStereo,
  output logic              fifoOn,
  output logic              autoInit,
  output logic              highChan,
  output logic [FREQ_W-1:0] freqHz,
  output logic [LEN_W-1:0]  bufPos,
  output logic              dreqHold,
  output logic              speakerOn,
  output logic              irqSet
);
  strobe_t strb;
  fmt_t    fmt;

  pcm_xfer_cmd u_cmd (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .busy     (busy),
    .strb     (strb)
  );

  pcm_xfer_dp #(.RATE_NUM(RATE_NUM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .xferStrobe (xferStrobe),
    .chanLen    (chanLen),
    .fmt        (fmt),
    .freqHz     (freqHz),
    .bufPos     (bufPos),
    .dreqHold   (dreqHold),
    .speakerOn  (speakerOn),
    .irqSet     (irqSet),
    .busy       (busy)
  );

  assign sampleWide   = fmt.wide;
  assign sampleSigned = fmt.sgn;
  assign sampleStereo = fmt.stereo;
  assign fifoOn       = fmt.fifo;
  assign autoInit     = fmt.autoInit;
  assign highChan     = fmt.highChan;
endmodule

// File: rtl/pcm_xfer_ctrl_chk.sv
module pcm_xfer_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        xferStrobe,
  input logic [15:0] chanLen,
  input logic        busy,
  input logic        autoInit,
  input logic [15:0] bufPos,
  input logic        dreqHold,
  input logic        speakerOn,
  input logic        irqSet
);
  assert_irq_after_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqSet |-> $past(xferStrobe));

  assert_single_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqSet && !autoInit && !$past(cmdValid)) |-> !dreqHold);

  assert_pos_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(xferStrobe && speakerOn && dreqHold && !busy && !cmdValid &&
          (16'(bufPos + 16'd1) == chanLen)) |-> (bufPos == 16'd0));

  assert_mute_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    $past(!speakerOn && !cmdValid && !busy) |-> $stable(bufPos));

  assert_busy_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(bufPos) && $stable(dreqHold)));
endmodule

bind pcm_xfer_ctrl pcm_xfer_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .xferStrobe (xferStrobe),
  .chanLen    (chanLen),
  .busy       (busy),
  .autoInit   (autoInit),
  .bufPos     (bufPos),
  .dreqHold   (dreqHold),
  .speakerOn  (speakerOn),
  .irqSet     (irqSet)
);

// File: tb/sim_pcm_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_pcm_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic        xferStrobe = 1'b0;
  logic [15:0] chanLen = 16'd1000;
  logic        busy, sampleWide, sampleSigned, sampleStereo, fifoOn, autoInit, highChan;
  logic [19:0] freqHz;
  logic [15:0] bufPos;
  logic        dreqHold, speakerOn, irqSet;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pcm_xfer_ctrl u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .xferStrobe(xferStrobe), .chanLen(chanLen), .busy(busy),
    .sampleWide(sampleWide), .sampleSigned(sampleSigned), .sampleStereo(sampleStereo),
    .fifoOn(fifoOn), .autoInit(autoInit), .highChan(highChan), .freqHz(freqHz),
    .bufPos(bufPos), .dreqHold(dreqHold), .speakerOn(speakerOn), .irqSet(irqSet)
  );

  function automatic int expFreq(input int tc);
    int t;
    t = 256 - tc;
    return (1000000 + t / 2) / t;
  endfunction

  function automatic int expSize(input logic [7:0] op, input int len);
    return (len + 1) * ((op[7:4] == 4'hB) ? 2 : 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdByte  = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic oneByte(output logic gotIrq);
    @(negedge clk);
    xferStrobe = 1'b1;
    @(negedge clk);
    xferStrobe = 1'b0;
    gotIrq = irqSet;
  endtask

  task automatic runBytes(input int n, output int irqCount, output int lastIrq);
    logic g;
    irqCount = 0;
    lastIrq  = 0;
    for (int i = 0; i < n; i++) begin
      oneByte(g);
      if (g) begin
        irqCount++;
        lastIrq = i + 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int cnt, last, tc, len, pos0, fq;
    logic [7:0] op, mode;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("reset hold", dreqHold, 0);
    chk("reset speaker", speakerOn, 0);
    chk("reset pos", bufPos, 0);
    chk("reset irq", irqSet, 0);
    chk("reset busy", busy, 0);

    // R5: direct rate, high byte first
    sendByte(8'h41); sendByte(8'h56); sendByte(8'h22);
    chk("R5 freq", freqHz, 16'h5622);

    // R1 R2 R3: 16-bit, fifo, auto, high channel, signed stereo, len 3
    sendByte(8'hB6); sendByte(8'h30); sendByte(8'h03); sendByte(8'h00);
    chk("R5 no busy", busy, 0);
    chk("R1 wide", sampleWide, 1);
    chk("R1 fifo", fifoOn, 1);
    chk("R1 auto", autoInit, 1);
    chk("R1 high", highChan, 1);
    chk("R2 signed", sampleSigned, 1);
    chk("R2 stereo", sampleStereo, 1);
    chk("R3 hold", dreqHold, 1);
    chk("R3 speaker", speakerOn, 1);
    chk("R3 pos", bufPos, 0);
    chk("R5 freq kept", freqHz, 16'h5622);

    // R9: size 8, auto reload
    runBytes(8, cnt, last);
    chk("R9 irq count block1", cnt, 1);
    chk("R9 irq at byte", last, 8);
    chk("R11 pos after 8", bufPos, 8);
    runBytes(8, cnt, last);
    chk("R9 reload irq at byte", last, 8);
    chk("R9 auto keeps hold", dreqHold, 1);

    // R11 R10: single 8-bit low channel, size 10, channel length 4
    chanLen = 16'd4;
    sendByte(8'hC0); sendByte(8'h00); sendByte(8'h09); sendByte(8'h00);
    chk("R1 8-bit", sampleWide, 0);
    chk("R1 low chan", highChan, 0);
    chk("R2 unsigned", sampleSigned, 0);
    runBytes(6, cnt, last);
    chk("R11 wrap pos", bufPos, 2);
    runBytes(4, cnt, last);
    chk("R10 irq at end", last, 4);
    chk("R10 hold released", dreqHold, 0);
    pos0 = bufPos;
    runBytes(3, cnt, last);
    chk("R10 no more bytes", bufPos, pos0);
    chk("R10 no more irq", cnt, 0);
    chanLen = 16'd1000;

    // R4: time constant, busy stalls start
    sendByte(8'h40); sendByte(8'hA5);
    sendByte(8'hC4); sendByte(8'h00); sendByte(8'h01); sendByte(8'h00);
    chk("R4 busy", busy, 1);
    chk("R4 hold before", dreqHold, 0);
    waitIdle();
    chk("R4 hold after", dreqHold, 1);
    chk("R4 freq A5", freqHz, expFreq(8'hA5));
    chk("R4 pos", bufPos, 0);

    // R6 R8: 0x48 size then 0x91 single
    sendByte(8'h48); sendByte(8'h00); sendByte(8'h05);
    sendByte(8'h91);
    waitIdle();
    chk("R8 single auto", autoInit, 0);
    chk("R8 wide", sampleWide, 0);
    chk("R8 stereo", sampleStereo, 0);
    chk("R8 fifo", fifoOn, 0);
    runBytes(5, cnt, last);
    chk("R6 irq at size", last, 5);
    chk("R6 irq count", cnt, 1);
    sendByte(8'h90);
    waitIdle();
    chk("R8 0x90 auto", autoInit, 1);
    chk("R8 0x90 hold", dreqHold, 1);

    // R7: resize keeps position and countdown
    sendByte(8'h41); sendByte(8'h2B); sendByte(8'h11);
    sendByte(8'hC0); sendByte(8'h00); sendByte(8'h09); sendByte(8'h00);
    runBytes(3, cnt, last);
    sendByte(8'h14); sendByte(8'h01); sendByte(8'h00);
    chk("R7 pos kept", bufPos, 3);
    chk("R7 single", autoInit, 0);
    chk("R7 hold", dreqHold, 1);
    runBytes(7, cnt, last);
    chk("R7 countdown kept", last, 7);
    chk("R7 one irq", cnt, 1);

    // R12: speaker off ignores strobes
    sendByte(8'hC4); sendByte(8'h00); sendByte(8'h20); sendByte(8'h00);
    runBytes(2, cnt, last);
    sendByte(8'hD3);
    chk("R12 speaker off", speakerOn, 0);
    runBytes(3, cnt, last);
    chk("R12 pos frozen", bufPos, 2);
    sendByte(8'hD1);
    runBytes(1, cnt, last);
    chk("R12 resumes", bufPos, 3);

    // R13: hold commands
    sendByte(8'hD0);
    chk("R13 D0 release", dreqHold, 0);
    sendByte(8'hD4);
    chk("R13 D4 hold", dreqHold, 1);
    sendByte(8'hDA);
    chk("R13 DA release", dreqHold, 0);
    chk("R13 DA auto off", autoInit, 0);

    // random starts with random time constants
    for (int k = 0; k < 8; k++) begin
      tc   = $urandom_range(0, 255);
      op   = (($urandom & 1) != 0 ? 8'hB0 : 8'hC0) | 8'($urandom & 7);
      mode = 8'($urandom) & 8'h30;
      len  = $urandom_range(0, 4);
      sendByte(8'h40); sendByte(8'(tc));
      sendByte(op); sendByte(mode); sendByte(8'(len)); sendByte(8'h00);
      waitIdle();
      fq = expFreq(tc);
      chk("R4 rand freq", freqHz, fq);
      chk("R1 rand wide", sampleWide, op[7:4] == 4'hB);
      chk("R1 rand auto", autoInit, op[2]);
      chk("R2 rand stereo", sampleStereo, mode[5]);
      runBytes(expSize(op, len), cnt, last);
      chk("R3 rand irq at size", last, expSize(op, len));
      chk("R9 rand irq count", cnt, 1);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule